// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block sets the run/stop state of a bank of ten buffered copies of one reference clock. It listens as a write-only target on a two-wire serial bus (I2C signalling). Each transfer starts with the target's write address. Two header bytes follow and are acknowledged, but their values are thrown away. After them come register bytes in a fixed order, starting at byte 0. No sub-address is taken, so a host that wants to change a later byte must resend every byte before it. Each accepted byte is acknowledged by pulling the data line low through an open-drain enable. The block never drives the data line for any other purpose.

SCL and SDA are oversampled by a fast system clock. Each enable bit then gates one output: an enabled output follows the reference clock, and a disabled output is held low. A new enable value reaches an output only while the reference clock is low, so stopping or restarting an output never cuts a pulse short. An active-low output-enable pin releases every output to high impedance, whatever the enable bits hold.

Top module: `clk_enable_ctrl`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START, including a repeated START, always restarts decoding at the address byte. A STOP ends the transfer.
- R2: Bytes are received MSB first. Only the address byte 0xD2 (7-bit address 0x69, write) is acknowledged. Any other address, including the read form 0xD3, is not acknowledged, and the rest of that transfer changes nothing.
- R3: The two bytes that follow an accepted address are acknowledged and their contents are discarded.
- R4: Up to 10 register bytes are acknowledged per transfer. An 11th or later register byte is not acknowledged and is discarded.
- R5: Register byte 0 bits 3..0 enable outputs 3..0. Byte 1 bits 7..4 enable outputs 9..6. Byte 4 bit 7 enables output 5 and bit 6 enables output 4. A bit value of 1 means the output runs. Every other byte and bit has no effect on the outputs.
- R6: After reset all ten outputs are enabled. Enable settings are kept across transfers, and a transfer that stops before a given byte leaves that byte's outputs unchanged.
- R7: An enabled output equals the reference clock. A disabled output is held low.
- R8: A new enable value reaches the outputs only in a system clock cycle where the reference clock is low. While the reference clock stays high, the outputs keep their previous enable state.
- R9: While the active-low output-enable input is low, the per-output drive enables `clk_drv` are all 0 (high impedance). When the input returns high, all ten are 1.
- R10: `sda_oe` is 1 only during the acknowledge slot of an accepted byte. It is asserted only while SCL is low and is 0 outside transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| oe_n | input | 1 | Active-low output enable for all clock outputs |
| clk_out | output | 10 | Gated copies of the reference clock |
| clk_drv | output | 10 | Per-output pad drive enable, 0 = high impedance |

## Verification
A table of four write transfers drives the enable map. One pattern sets every don't-care bit while clearing every mapped bit. Two complementary alternating patterns follow, then an all-on pattern. Together they separate a correct bit-to-output mapping from shifted, swapped or wrongly ordered mappings. Directed transfers then try the cases that the mapping alone does not reach:
- a foreign address and a read address, which show whether the address is decoded;
- eleven register bytes, which locate the acknowledge cut-off;
- a header-only transfer and a byte-0-only transfer, which test retention;
- a repeated START, which must restart at the address;
- a write while the reference clock is frozen high, which tests that the new enables are held back until it goes low.

// File: rtl/clkgate_pkg.sv
// Shared types and the output-to-register-bit map for the clock enable controller.
// Assumes a fixed bank of ten outputs spread over register bytes 0, 1 and 4.
package clkgate_pkg;

    localparam int NUM_CLK = 10;

    typedef enum logic [1:0] {
        ST_IDLE,   // bus free or between transfers
        ST_RECV,   // shifting in a byte
        ST_ACK,    // holding the acknowledge slot
        ST_SKIP    // byte refused, wait for START or STOP
    } xfer_state_t;

    // Register byte that carries the enable of output i (byte 0: outputs 0..3, byte 4: 4..5, byte 1: 6..9)
    function automatic int map_byte(input int i);
        if (i < 4)      return 0;
        else if (i < 6) return 4;
        else            return 1;
    endfunction

    // Bit inside that byte that carries the enable of output i
    function automatic int map_bit(input int i);
        if (i < 4)       return i;
        else if (i == 4) return 6;
        else if (i == 5) return 7;
        else             return i - 2;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the system clock domain with two-flop synchronizers
// and derives one-cycle edge and bus-condition pulses.
// Assumes the system clock runs at least 8x the SCL rate; idle lines read high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_pipe, sda_pipe;
    logic       scl_q, sda_q;

    // Two-flop synchronizer plus one history flop per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    assign scl_s = scl_pipe[1];
    assign sda_s = sda_pipe[1];

    // Edge and START/STOP decoding on the synchronized lines
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_wr_engine.sv
// Write-only byte engine: matches the address, acknowledges the header bytes and
// up to MAX_DATA register bytes, and issues one write strobe per register byte.
// Assumes synchronized lines and edge pulses from i2c_line_sync; never stretches SCL.
module i2c_wr_engine
    import clkgate_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         HDR_BYTES = 2,
    parameter int         MAX_DATA  = 10,
    localparam int        LAST_IDX  = HDR_BYTES + MAX_DATA,
    localparam int        IDX_W     = $clog2(LAST_IDX + 2),
    localparam int        DIDX_W    = $clog2(MAX_DATA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [DIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data
);
    xfer_state_t      state;
    logic [IDX_W-1:0] byte_idx;
    logic [2:0]       bit_cnt;
    logic             byte_full;
    logic [7:0]       shreg;
    logic             accept;

    // Decide whether the byte just received earns an acknowledge
    always_comb begin
        if (byte_idx == '0) accept = (shreg == {DEV_ADDR, 1'b0});
        else                accept = (byte_idx <= IDX_W'(LAST_IDX));
    end

    // Transfer sequencer: bus conditions first, then bit shifting and ack slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            byte_idx  <= '0;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state     <= ST_RECV;
                byte_idx  <= '0;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_fall && byte_full) begin
                            if (accept) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                if (byte_idx > IDX_W'(HDR_BYTES)) begin
                                    wr_stb  <= 1'b1;
                                    wr_idx  <= DIDX_W'(byte_idx - IDX_W'(HDR_BYTES + 1));
                                    wr_data <= shreg;
                                end
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (scl_rise && !byte_full) begin
                            shreg     <= {shreg[6:0], sda_s};
                            bit_cnt   <= bit_cnt + 3'd1;
                            byte_full <= (bit_cnt == 3'd7);
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe    <= 1'b0;
                            byte_idx  <= byte_idx + IDX_W'(1);
                            bit_cnt   <= '0;
                            byte_full <= 1'b0;
                            state     <= ST_RECV;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a START always re-arms address decoding
    assert_start_rearms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RECV && byte_idx == '0 && !sda_oe));
    // R1: a STOP returns the engine to idle with the line released
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));
    // R10: the acknowledge pull-down starts only while SCL is low
    assert_ack_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // R10: the pull-down is only held inside the ack slot
    assert_ack_in_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK));
    // R4: the byte index never runs past the refused-byte slot
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= IDX_W'(LAST_IDX + 1));
    // R2/R3: a register write comes only after address and both header bytes
    assert_wr_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (byte_idx > IDX_W'(HDR_BYTES) && state == ST_ACK));

endmodule

// File: rtl/clk_en_regs.sv
// Holds the requested enable bit of every output and updates it from register
// writes according to the package map; reset state is all outputs enabled.
// Assumes one write strobe per accepted register byte.
module clk_en_regs
    import clkgate_pkg::*;
#(
    parameter int  N_OUT  = NUM_CLK,
    parameter int  DIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DIDX_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    output logic [N_OUT-1:0]  en_req
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_bit
        localparam int BYTE_SEL = map_byte(i);
        localparam int BIT_SEL  = map_bit(i);
        // Capture this output's enable when its register byte is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_req[i] <= 1'b1;
            else if (wr_stb && wr_idx == DIDX_W'(BYTE_SEL))
                en_req[i] <= wr_data[BIT_SEL];
        end
    end

    // R6: the cycle after reset every output is requested on
    assert_reset_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_req == '1));
    // R5: requests move only on a register write
    assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(en_req));

endmodule

// File: rtl/clk_gate_bank.sv
// Applies enable requests to the reference clock without truncating pulses and
// drives the per-output pad enables from the active-low output enable.
// Assumes ref_clk is slow enough that the system clock sees every low phase.
module clk_gate_bank
    import clkgate_pkg::*;
#(
    parameter int N_OUT = NUM_CLK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             oe_n,
    input  logic [N_OUT-1:0] en_req,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_drv
);
    logic [N_OUT-1:0] en_eff;

    // Take on new requests only while the reference clock is low
    always_ff @(posedge clk) begin
        if (!rst_n)        en_eff <= '1;
        else if (!ref_clk) en_eff <= en_req;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign clk_out[i] = ref_clk & en_eff[i];
        assign clk_drv[i] = oe_n;
    end

    // R8: the applied enables never move across a high reference phase
    assert_no_change_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_clk) && ref_clk) |-> $stable(en_eff));
    // R8: once the reference has been low, applied enables match the request
    assert_follow_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ref_clk) && $stable(en_req)) |-> (en_eff == en_req));

endmodule

// File: rtl/clk_enable_ctrl.sv
// Top: serial-programmed enable controller for ten gated reference clock outputs.
// Assumes clk runs at least 8x SCL and samples every ref_clk low phase.
module clk_enable_ctrl
    import clkgate_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         HDR_BYTES = 2,
    parameter int         MAX_DATA  = 10,
    localparam int        DIDX_W    = $clog2(MAX_DATA)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               ref_clk,
    input  logic               oe_n,
    output logic [NUM_CLK-1:0] clk_out,
    output logic [NUM_CLK-1:0] clk_drv
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb;
    logic [DIDX_W-1:0] wr_idx;
    logic [7:0]        wr_data;
    logic [NUM_CLK-1:0] en_req;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_wr_engine #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES), .MAX_DATA(MAX_DATA)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    clk_en_regs #(.N_OUT(NUM_CLK), .DIDX_W(DIDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .en_req(en_req)
    );

    clk_gate_bank #(.N_OUT(NUM_CLK)) u_gate (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .oe_n(oe_n),
        .en_req(en_req), .clk_out(clk_out), .clk_drv(clk_drv)
    );

    // R9: pads are released whenever the output enable pin is low
    assert_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (clk_drv == '0));
    // R7: a gated output is never high while the reference clock is low
    assert_low_with_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_clk |-> (clk_out == '0));

endmodule

// File: tb/sim_clk_enable_ctrl.sv
module sim_clk_enable_ctrl;
    localparam int H = 20;      // SCL half period in system cycles
    // {byte0, byte1, byte4, expected clk_out in a high ref phase}
    localparam logic [33:0] VEC [4] = '{
        {8'hF0, 8'h0F, 8'h3F, 10'h000},
        {8'h0A, 8'hA0, 8'h80, 10'h2AA},
        {8'h05, 8'h50, 8'h40, 10'h155},
        {8'hFF, 8'hFF, 8'hC0, 10'h3FF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic ref_clk = 1'b0, ref_run = 1'b1, ref_hold = 1'b0;
    logic oe_n = 1'b1;
    logic sda_oe;
    logic [9:0] clk_out, clk_drv;
    wire  sda_line = sda_m & ~sda_oe;
    int   n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    clk_enable_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .ref_clk(ref_clk), .oe_n(oe_n), .clk_out(clk_out), .clk_drv(clk_drv)
    );

    // Reference clock: toggles every 5 system cycles, or parks at ref_hold
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (ref_run) begin
                cnt++;
                if (cnt >= 5) begin cnt = 0; ref_clk = ~ref_clk; end
            end else ref_clk = ref_hold;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic i2c_start;
        scl_m = 1'b0; wcyc(2); sda_m = 1'b1; wcyc(H);
        scl_m = 1'b1; wcyc(H); sda_m = 1'b0; wcyc(H);
        scl_m = 1'b0; wcyc(2);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wcyc(H); scl_m = 1'b1; wcyc(H); sda_m = 1'b1; wcyc(H);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wcyc(H); scl_m = 1'b1; wcyc(H); scl_m = 1'b0; wcyc(2);
        end
        sda_m = 1'b1; wcyc(H); scl_m = 1'b1; wcyc(H / 2);
        ack = sda_oe;
        wcyc(H / 2); scl_m = 1'b0; wcyc(2);
    endtask

    // Address, two header bytes, nd register bytes, STOP; ackv bit k = byte k acked
    task automatic xfer(input logic [7:0] addr, input int nd, input logic [7:0] d [11],
                        output logic [13:0] ackv);
        logic a;
        ackv = '0;
        i2c_start;
        i2c_byte(addr, a);  ackv[0] = a;
        i2c_byte(8'h3C, a); ackv[1] = a;
        i2c_byte(8'hC3, a); ackv[2] = a;
        for (int k = 0; k < nd; k++) begin i2c_byte(d[k], a); ackv[3 + k] = a; end
        i2c_stop;
    endtask

    task automatic sample_high(output logic [9:0] v);
        repeat (12) @(posedge clk);
        #1;
        while (ref_clk !== 1'b1) begin @(posedge clk); #1; end
        v = clk_out;
    endtask

    task automatic sample_low(output logic [9:0] v);
        @(posedge clk); #1;
        while (ref_clk !== 1'b0) begin @(posedge clk); #1; end
        v = clk_out;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  d [11];
        logic [13:0] ackv;
        logic [9:0]  v;
        logic        a;

        wcyc(6); rst_n = 1'b1; wcyc(4);
        // Reset state
        sample_high(v); chk(v == 10'h3FF, "R6 reset all on", 16'(v), 16'h3FF);
        chk(sda_oe == 1'b0, "R10 idle no pull-down", 16'(sda_oe), 16'h0);
        chk(clk_drv == 10'h3FF, "R9 drive after reset", 16'(clk_drv), 16'h3FF);

        // Table of mapping patterns (R2 R3 R5 R7)
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 11; k++) d[k] = 8'h00;
            d[0] = VEC[t][33:26]; d[1] = VEC[t][25:18]; d[2] = 8'hFF; d[3] = 8'hFF;
            d[4] = VEC[t][17:10];
            xfer(8'hD2, 5, d, ackv);
            chk(ackv == 14'h00FF, "R3 addr+header+data acked", 16'(ackv), 16'h00FF);
            sample_high(v); chk(v == VEC[t][9:0], "R5 enable map", 16'(v), 16'(VEC[t][9:0]));
            sample_low(v);  chk(v == 10'h000, "R7 low with ref", 16'(v), 16'h000);
        end

        // Foreign address: no ack, no effect (R2)
        for (int k = 0; k < 11; k++) d[k] = 8'h00;
        xfer(8'hD4, 5, d, ackv);
        chk(ackv == 14'h0, "R2 foreign address nack", 16'(ackv), 16'h0);
        sample_high(v); chk(v == 10'h3FF, "R2 foreign address ignored", 16'(v), 16'h3FF);
        // Read request (R2)
        xfer(8'hD3, 0, d, ackv);
        chk(ackv == 14'h0, "R2 read nack", 16'(ackv), 16'h0);
        chk(sda_oe == 1'b0, "R10 released after stop", 16'(sda_oe), 16'h0);

        // Eleven register bytes: 11th refused (R4)
        xfer(8'hD2, 11, d, ackv);
        chk(ackv == 14'h1FFF, "R4 ack cut-off", 16'(ackv), 16'h1FFF);
        sample_high(v); chk(v == 10'h000, "R4 ten bytes applied", 16'(v), 16'h000);

        // Header-only transfer keeps state (R6)
        xfer(8'hD2, 0, d, ackv);
        chk(ackv == 14'h0007, "R3 header-only acked", 16'(ackv), 16'h0007);
        sample_high(v); chk(v == 10'h000, "R6 retained", 16'(v), 16'h000);

        // Byte 0 only (R5 R6)
        d[0] = 8'h0F;
        xfer(8'hD2, 1, d, ackv);
        chk(ackv == 14'h000F, "R5 byte0 acked", 16'(ackv), 16'h000F);
        sample_high(v); chk(v == 10'h00F, "R5 byte0 only", 16'(v), 16'h00F);

        // Repeated START restarts at address (R1)
        i2c_start;
        i2c_byte(8'hD2, a); i2c_byte(8'h11, a); i2c_byte(8'h22, a);
        i2c_start;
        i2c_byte(8'hD2, a); chk(a == 1'b1, "R1 repeated start address acked", 16'(a), 16'h1);
        i2c_byte(8'h00, a); i2c_byte(8'h00, a);
        i2c_byte(8'h03, a); chk(a == 1'b1, "R1 byte0 after restart acked", 16'(a), 16'h1);
        i2c_stop;
        sample_high(v); chk(v == 10'h003, "R1 restart decoded from address", 16'(v), 16'h003);

        // Write while ref frozen high: held until a low phase (R8)
        ref_hold = 1'b1; ref_run = 1'b0; wcyc(2);
        d[0] = 8'h0F; d[1] = 8'hF0; d[2] = 8'h00; d[3] = 8'h00; d[4] = 8'hC0;
        xfer(8'hD2, 5, d, ackv);
        wcyc(20);
        @(posedge clk); #1;
        chk(clk_out == 10'h003, "R8 held while ref high", 16'(clk_out), 16'h003);
        @(negedge clk); ref_hold = 1'b0; wcyc(3); ref_hold = 1'b1; wcyc(3);
        @(posedge clk); #1;
        chk(clk_out == 10'h3FF, "R8 applied after low phase", 16'(clk_out), 16'h3FF);
        @(negedge clk); ref_run = 1'b1;

        // Global output enable (R9)
        oe_n = 1'b0; wcyc(2);
        chk(clk_drv == 10'h000, "R9 tri-state", 16'(clk_drv), 16'h000);
        oe_n = 1'b1; wcyc(2);
        chk(clk_drv == 10'h3FF, "R9 drive restored", 16'(clk_drv), 16'h3FF);
        sample_high(v); chk(v == 10'h3FF, "R9 enables kept", 16'(v), 16'h3FF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule